// File: doc/BRIEF.md
# Host Link Streaming Session Controller

This block manages one streaming session between a chassis data path and the host link. It takes the link status, an arm request from the host, a capture trigger, overflow and DMA error flags from the data path, and a free-running timestamp. From these it drives a streaming enable and an inhibit for synchronized operations. Every state change is written as a record of a 4-bit event code and a 32-bit timestamp into a small log queue that the host drains.

A session moves through a fixed loop: Connected, Armed, Streaming, Fault, Recover, Resume, and back to Streaming. Each state other than Streaming has its own programmable cycle limit. When that limit runs out, the controller is forced into Fault. On a fault, the inhibit rises before recovery starts. Samples already captured are kept: the controller records the last valid sample count instead of discarding anything. Per-session counters hold the number of reconnects and the number of timeouts. The physical link, the DMA engine and the host software appear only as status and handshake signals.

Top module: `stream_session_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `stream_en_o` and `sync_inhibit_o` are low. The first logged record is the boot code 0xC OR `rst_cause_i`, stamped with the `ts_i` value present at the first clock edge after reset is released.
- R2: In Connected, a high `arm_i` with the link up moves the session to Armed and logs code 0x1. In Armed, `trig_i` moves it to Streaming and logs code 0x2. `stream_en_o` is high only in Streaming.
- R3: A link drop in Connected, Armed, Streaming or Resume forces Fault and logs code 0x3. In Streaming, a DMA error (code 0x4) or a buffer overflow (code 0x5) also forces Fault. The priority is link drop, then DMA error, then overflow. `sync_inhibit_o` is high in Fault, Recover and Resume, and `stream_en_o` is low there.
- R4: Fault holds while either error flag is high. Once both flags are clear, it moves to Recover and logs code 0x7. Recover moves to Resume when the link is up and logs code 0x8. Each Recover-to-Resume step adds one to `reconnect_cnt_o`.
- R5: Resume moves to Streaming and logs code 0x9 only when the link is up and `arm_i` is high.
- R6: With a nonzero limit N for the current non-streaming state, a session that stays in that state for N cycles enters Fault. The timeout is logged with code 0x6 and `timeout_cnt_o` goes up by one. A timeout inside Fault re-enters Fault. A limit of 0 disables that state's timeout.
- R7: `sample_i` strobes are counted only in Streaming. Other strobes are ignored. On each exit from Streaming to Fault, `last_valid_o` takes the running count. The count is never cleared by a fault.
- R8: Each record carries the `ts_i` value at the clock edge of its transition. Records are read in order through `log_rd_i`, and the head is visible whenever `log_empty_o` is low.
- R9: If a record arrives while the 16-entry log is full and no read occurs in that cycle, the oldest record is dropped and `log_ovf_o` is set. `log_ovf_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Host link status |
| arm_i | input | 1 | Host arm request |
| trig_i | input | 1 | Capture start trigger |
| buf_ovf_i | input | 1 | Data path buffer overflow flag |
| dma_err_i | input | 1 | DMA error flag |
| sample_i | input | 1 | One strobe per captured sample |
| rst_cause_i | input | 2 | Reset cause folded into the boot record |
| ts_i | input | TS_W | Free-running timestamp |
| tmo_conn_i | input | TMO_W | Connected cycle limit (0 = none) |
| tmo_armed_i | input | TMO_W | Armed cycle limit (0 = none) |
| tmo_fault_i | input | TMO_W | Fault cycle limit (0 = none) |
| tmo_recov_i | input | TMO_W | Recover cycle limit (0 = none) |
| tmo_resume_i | input | TMO_W | Resume cycle limit (0 = none) |
| log_rd_i | input | 1 | Pop the head record |
| stream_en_o | output | 1 | Streaming enable |
| sync_inhibit_o | output | 1 | Inhibit for synchronized operations |
| last_valid_o | output | SAMP_W | Sample count at the last fault exit from Streaming |
| reconnect_cnt_o | output | CNT_W | Reconnects in this session |
| timeout_cnt_o | output | CNT_W | Timeouts in this session |
| log_empty_o | output | 1 | Log queue empty |
| log_code_o | output | 4 | Head record event code |
| log_ts_o | output | TS_W | Head record timestamp |
| log_ovf_o | output | 1 | Sticky log overflow flag |

## Verification
The hardest situation to reach from the ports is the drop of the oldest log record. It needs more than sixteen records written with no reads in between, and ordinary transitions come far too slowly for that. The stimulus stops draining the log, sets the Fault limit to one cycle and holds the overflow flag high. Fault then times out and re-enters itself on every cycle, which produces one timeout record per clock. The bench keeps only the last sixteen expected records and checks the sticky flag after the log is drained. The Resume timeout is reached by keeping arm low after a reconnect. The exact order of codes is checked across a link drop during Streaming.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   localparam int unsigned EV_W = 4;

   typedef enum logic [2:0] {
      S_CONN   = 3'd0,
      S_ARMED  = 3'd1,
      S_STREAM = 3'd2,
      S_FAULT  = 3'd3,
      S_RECOV  = 3'd4,
      S_RESUME = 3'd5
   } sess_state_e;

   typedef logic [EV_W-1:0] ev_code_t;

   localparam ev_code_t EV_ARMED     = 4'h1;
   localparam ev_code_t EV_START     = 4'h2;
   localparam ev_code_t EV_LINK_DOWN = 4'h3;
   localparam ev_code_t EV_DMA_ERR   = 4'h4;
   localparam ev_code_t EV_BUF_OVF   = 4'h5;
   localparam ev_code_t EV_TIMEOUT   = 4'h6;
   localparam ev_code_t EV_RECOVER   = 4'h7;
   localparam ev_code_t EV_LINK_UP   = 4'h8;
   localparam ev_code_t EV_RESTART   = 4'h9;
   localparam ev_code_t EV_BOOT_BASE = 4'hC;
endpackage

// File: rtl/ssc_state_timer.sv
module ssc_state_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expire_o
);
   logic [TMO_W-1:0] cnt_q;

   generate
      if (TMO_W < 2) begin : g_bad_width
         $error("ssc_state_timer: TMO_W must be at least 2");
      end
   endgenerate

   assign expire_o = (limit_i != '0) && (cnt_q == limit_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (cnt_q != '1) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: a state entry always begins its window from zero
   assert_window_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/ssc_session_fsm.sv
module ssc_session_fsm
   import ssc_pkg::*;
#(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             link_up_i,
   input  logic             arm_i,
   input  logic             trig_i,
   input  logic             buf_ovf_i,
   input  logic             dma_err_i,
   input  logic [1:0]       rst_cause_i,
   input  logic [TMO_W-1:0] tmo_conn_i,
   input  logic [TMO_W-1:0] tmo_armed_i,
   input  logic [TMO_W-1:0] tmo_fault_i,
   input  logic [TMO_W-1:0] tmo_recov_i,
   input  logic [TMO_W-1:0] tmo_resume_i,
   input  logic             expire_i,
   output logic [TMO_W-1:0] limit_o,
   output logic             restart_o,
   output logic             evt_vld_o,
   output ev_code_t         evt_code_o,
   output logic             tmo_hit_o,
   output logic             reconn_o,
   output logic             halt_o,
   output logic             in_stream_o,
   output logic             stream_en_o,
   output logic             sync_inhibit_o
);
   sess_state_e st_q, st_d;
   logic        boot_q;
   logic        go;
   ev_code_t    code;
   logic        hit;

   always_comb begin
      st_d = st_q;
      go   = 1'b0;
      code = '0;
      hit  = 1'b0;
      if (!boot_q) begin
         go   = 1'b1;
         code = EV_BOOT_BASE | ev_code_t'({2'b00, rst_cause_i});
      end else begin
         unique case (st_q)
            S_CONN: begin
               if (!link_up_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_LINK_DOWN;
               end else if (arm_i) begin
                  st_d = S_ARMED;  go = 1'b1; code = EV_ARMED;
               end else if (expire_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_TIMEOUT; hit = 1'b1;
               end
            end
            S_ARMED: begin
               if (!link_up_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_LINK_DOWN;
               end else if (trig_i) begin
                  st_d = S_STREAM; go = 1'b1; code = EV_START;
               end else if (expire_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_TIMEOUT; hit = 1'b1;
               end
            end
            S_STREAM: begin
               if (!link_up_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_LINK_DOWN;
               end else if (dma_err_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_DMA_ERR;
               end else if (buf_ovf_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_BUF_OVF;
               end
            end
            S_FAULT: begin
               if (!dma_err_i && !buf_ovf_i) begin
                  st_d = S_RECOV;  go = 1'b1; code = EV_RECOVER;
               end else if (expire_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_TIMEOUT; hit = 1'b1;
               end
            end
            S_RECOV: begin
               if (link_up_i) begin
                  st_d = S_RESUME; go = 1'b1; code = EV_LINK_UP;
               end else if (expire_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_TIMEOUT; hit = 1'b1;
               end
            end
            S_RESUME: begin
               if (!link_up_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_LINK_DOWN;
               end else if (arm_i) begin
                  st_d = S_STREAM; go = 1'b1; code = EV_RESTART;
               end else if (expire_i) begin
                  st_d = S_FAULT;  go = 1'b1; code = EV_TIMEOUT; hit = 1'b1;
               end
            end
            default: begin
               st_d = S_FAULT; go = 1'b1; code = EV_TIMEOUT; hit = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= S_CONN;
         boot_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         boot_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (st_q)
         S_CONN:   limit_o = tmo_conn_i;
         S_ARMED:  limit_o = tmo_armed_i;
         S_FAULT:  limit_o = tmo_fault_i;
         S_RECOV:  limit_o = tmo_recov_i;
         S_RESUME: limit_o = tmo_resume_i;
         default:  limit_o = '0;
      endcase
   end

   assign restart_o      = go;
   assign evt_vld_o      = go;
   assign evt_code_o     = code;
   assign tmo_hit_o      = hit;
   assign reconn_o       = go && (st_q == S_RECOV) && (st_d == S_RESUME);
   assign halt_o         = (st_q == S_STREAM) && (st_d == S_FAULT);
   assign in_stream_o    = (st_q == S_STREAM);
   assign stream_en_o    = (st_q == S_STREAM);
   assign sync_inhibit_o = (st_q == S_FAULT) || (st_q == S_RECOV) || (st_q == S_RESUME);

   // R3: a link drop while streaming raises the inhibit on the next cycle
   assert_drop_inhibits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == S_STREAM && !link_up_i) |=> (sync_inhibit_o && !stream_en_o));
   // R4: Fault is held while either error flag remains high (unless timing out to itself)
   assert_fault_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == S_FAULT && (dma_err_i || buf_ovf_i)) |=> (st_q == S_FAULT));
   // R5: a restart of streaming from Resume needs link and arm in the prior cycle
   assert_resume_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == S_STREAM && $past(st_q) == S_RESUME) |-> $past(link_up_i && arm_i));
   // R8: every state change is accompanied by a logged record
   assert_move_logged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q != $past(st_q)) |-> $past(evt_vld_o));
endmodule

// File: rtl/ssc_session_stats.sv
module ssc_session_stats #(
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned SAMP_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_stream_i,
   input  logic              sample_i,
   input  logic              halt_i,
   input  logic              reconn_i,
   input  logic              tmo_hit_i,
   output logic [SAMP_W-1:0] last_valid_o,
   output logic [CNT_W-1:0]  reconnect_cnt_o,
   output logic [CNT_W-1:0]  timeout_cnt_o
);
   logic [SAMP_W-1:0] samp_q, samp_d;

   generate
      if (CNT_W < 2 || SAMP_W < 2) begin : g_bad_width
         $error("ssc_session_stats: counter widths must be at least 2");
      end
   endgenerate

   assign samp_d = samp_q + SAMP_W'(in_stream_i && sample_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         samp_q          <= '0;
         last_valid_o    <= '0;
         reconnect_cnt_o <= '0;
         timeout_cnt_o   <= '0;
      end else begin
         samp_q <= samp_d;
         if (halt_i)    last_valid_o    <= samp_d;
         if (reconn_i)  reconnect_cnt_o <= reconnect_cnt_o + 1'b1;
         if (tmo_hit_i) timeout_cnt_o   <= timeout_cnt_o + 1'b1;
      end
   end

   // R6: each forced timeout advances the timeout counter by exactly one
   assert_tmo_counted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo_hit_i |=> (timeout_cnt_o == $past(timeout_cnt_o) + 1'b1));
   // R7: the preserved count only moves on an exit from Streaming into Fault
   assert_mark_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !halt_i |=> $stable(last_valid_o));
   // R7: outside Streaming the running sample count does not move
   assert_no_count_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_stream_i |=> $stable(samp_q));
endmodule

// File: rtl/ssc_event_log.sv
module ssc_event_log
   import ssc_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned TS_W        = 32,
   parameter bit          DROP_OLDEST = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            wr_i,
   input  ev_code_t        wr_code_i,
   input  logic [TS_W-1:0] wr_ts_i,
   input  logic            rd_i,
   output logic            empty_o,
   output ev_code_t        code_o,
   output logic [TS_W-1:0] ts_o,
   output logic            ovf_o
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ssc_event_log: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   ev_code_t        code_mem [DEPTH];
   logic [TS_W-1:0] ts_mem   [DEPTH];
   logic [AW-1:0]   wp_q, rp_q;
   logic [AW:0]     cnt_q;
   logic            full, do_rd, wr_ok, drop, lost, adv_rd;

   assign full    = (cnt_q == FULL_CNT);
   assign empty_o = (cnt_q == '0);
   assign do_rd   = rd_i && !empty_o;
   assign lost    = wr_i && full && !do_rd;
   assign adv_rd  = do_rd || drop;

   generate
      if (DROP_OLDEST) begin : g_drop_head
         assign wr_ok = wr_i;
         assign drop  = lost;
         // R9: a write into a full log without a read keeps it full
         assert_stays_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (full && wr_i && !rd_i) |=> full);
      end else begin : g_drop_tail
         assign wr_ok = wr_i && !lost;
         assign drop  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (wr_ok) begin
         code_mem[wp_q] <= wr_code_i;
         ts_mem[wp_q]   <= wr_ts_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         ovf_o <= 1'b0;
      end else begin
         if (wr_ok)  wp_q <= wp_q + 1'b1;
         if (adv_rd) rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + (AW+1)'(wr_ok) - (AW+1)'(adv_rd);
         if (lost) ovf_o <= 1'b1;
      end
   end

   assign code_o = code_mem[rp_q];
   assign ts_o   = ts_mem[rp_q];

   // R9: occupancy never exceeds the configured depth
   assert_depth_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= FULL_CNT);
   // R9: the overflow flag is sticky
   assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> ovf_o);
endmodule

// File: rtl/stream_session_ctrl.sv
module stream_session_ctrl
   import ssc_pkg::*;
#(
   parameter int unsigned TS_W        = 32,
   parameter int unsigned TMO_W       = 16,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SAMP_W      = 32,
   parameter int unsigned LOG_DEPTH   = 16,
   parameter bit          DROP_OLDEST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              link_up_i,
   input  logic              arm_i,
   input  logic              trig_i,
   input  logic              buf_ovf_i,
   input  logic              dma_err_i,
   input  logic              sample_i,
   input  logic [1:0]        rst_cause_i,
   input  logic [TS_W-1:0]   ts_i,
   input  logic [TMO_W-1:0]  tmo_conn_i,
   input  logic [TMO_W-1:0]  tmo_armed_i,
   input  logic [TMO_W-1:0]  tmo_fault_i,
   input  logic [TMO_W-1:0]  tmo_recov_i,
   input  logic [TMO_W-1:0]  tmo_resume_i,
   input  logic              log_rd_i,
   output logic              stream_en_o,
   output logic              sync_inhibit_o,
   output logic [SAMP_W-1:0] last_valid_o,
   output logic [CNT_W-1:0]  reconnect_cnt_o,
   output logic [CNT_W-1:0]  timeout_cnt_o,
   output logic              log_empty_o,
   output logic [EV_W-1:0]   log_code_o,
   output logic [TS_W-1:0]   log_ts_o,
   output logic              log_ovf_o
);
   generate
      if (TS_W < 8) begin : g_bad_ts
         $error("stream_session_ctrl: TS_W must be at least 8");
      end
   endgenerate

   logic [TMO_W-1:0] limit;
   logic             restart, expire, evt_vld, tmo_hit, reconn, halt, in_stream;
   ev_code_t         evt_code;

   ssc_state_timer #(.TMO_W(TMO_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .limit_i   (limit),
      .expire_o  (expire)
   );

   ssc_session_fsm #(.TMO_W(TMO_W)) u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .link_up_i      (link_up_i),
      .arm_i          (arm_i),
      .trig_i         (trig_i),
      .buf_ovf_i      (buf_ovf_i),
      .dma_err_i      (dma_err_i),
      .rst_cause_i    (rst_cause_i),
      .tmo_conn_i     (tmo_conn_i),
      .tmo_armed_i    (tmo_armed_i),
      .tmo_fault_i    (tmo_fault_i),
      .tmo_recov_i    (tmo_recov_i),
      .tmo_resume_i   (tmo_resume_i),
      .expire_i       (expire),
      .limit_o        (limit),
      .restart_o      (restart),
      .evt_vld_o      (evt_vld),
      .evt_code_o     (evt_code),
      .tmo_hit_o      (tmo_hit),
      .reconn_o       (reconn),
      .halt_o         (halt),
      .in_stream_o    (in_stream),
      .stream_en_o    (stream_en_o),
      .sync_inhibit_o (sync_inhibit_o)
   );

   ssc_session_stats #(.CNT_W(CNT_W), .SAMP_W(SAMP_W)) u_stats (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .in_stream_i     (in_stream),
      .sample_i        (sample_i),
      .halt_i          (halt),
      .reconn_i        (reconn),
      .tmo_hit_i       (tmo_hit),
      .last_valid_o    (last_valid_o),
      .reconnect_cnt_o (reconnect_cnt_o),
      .timeout_cnt_o   (timeout_cnt_o)
   );

   ssc_event_log #(.DEPTH(LOG_DEPTH), .TS_W(TS_W), .DROP_OLDEST(DROP_OLDEST)) u_log (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (evt_vld),
      .wr_code_i (evt_code),
      .wr_ts_i   (ts_i),
      .rd_i      (log_rd_i),
      .empty_o   (log_empty_o),
      .code_o    (log_code_o),
      .ts_o      (log_ts_o),
      .ovf_o     (log_ovf_o)
   );
endmodule

// File: tb/stream_session_ctrl_bench.sv
`timescale 1ns/1ps
module stream_session_ctrl_bench;
   localparam int TS_W = 32, TMO_W = 16, CNT_W = 8, SAMP_W = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic link_up, arm, trig, buf_ovf, dma_err, sample, log_rd;
   logic [1:0] cause;
   logic [TS_W-1:0] ts = '0;
   logic [TMO_W-1:0] tmo_conn, tmo_armed, tmo_fault, tmo_recov, tmo_resume;
   logic stream_en, inhibit, log_empty, log_ovf;
   logic [SAMP_W-1:0] last_valid;
   logic [CNT_W-1:0] reconn_cnt, tmo_cnt;
   logic [3:0] log_code;
   logic [TS_W-1:0] log_ts;

   stream_session_ctrl u_stream_session_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .link_up_i(link_up), .arm_i(arm), .trig_i(trig),
      .buf_ovf_i(buf_ovf), .dma_err_i(dma_err), .sample_i(sample), .rst_cause_i(cause),
      .ts_i(ts), .tmo_conn_i(tmo_conn), .tmo_armed_i(tmo_armed), .tmo_fault_i(tmo_fault),
      .tmo_recov_i(tmo_recov), .tmo_resume_i(tmo_resume), .log_rd_i(log_rd),
      .stream_en_o(stream_en), .sync_inhibit_o(inhibit), .last_valid_o(last_valid),
      .reconnect_cnt_o(reconn_cnt), .timeout_cnt_o(tmo_cnt), .log_empty_o(log_empty),
      .log_code_o(log_code), .log_ts_o(log_ts), .log_ovf_o(log_ovf)
   );

   typedef struct packed { logic [3:0] code; logic [31:0] stamp; } ev_t;
   ev_t exp_q[$];
   ev_t head;
   int  n_cmp = 0, n_bad = 0;
   bit  mon_en = 1'b1, done = 1'b0;

   always @(negedge clk) ts <= ts + 1'b1;

   // monitor: pop the log and compare against the expected queue (R8)
   always @(negedge clk) begin
      log_rd <= 1'b0;
      if (rst_n && mon_en && !log_empty) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R8 record actual code=%h ts=%0d expected none", log_code, log_ts);
         end else begin
            head = exp_q.pop_front();
            if (log_code !== head.code || log_ts !== head.stamp) begin
               n_bad++;
               $display("FAIL R8 record actual code=%h ts=%0d expected code=%h ts=%0d",
                        log_code, log_ts, head.code, head.stamp);
            end
         end
         log_rd <= 1'b1;
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic expect_ev(logic [3:0] c, logic [31:0] t);
      exp_q.push_back({c, t});
   endtask

   task automatic check(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] t0;
      ev_t tmp[$];
      log_rd = 1'b0;
      link_up = 1'b1; arm = 1'b0; trig = 1'b0; buf_ovf = 1'b0; dma_err = 1'b0; sample = 1'b0;
      cause = 2'd2;
      tmo_conn = '0; tmo_armed = '0; tmo_fault = 16'd20; tmo_recov = 16'd40; tmo_resume = 16'd20;
      tick(3);
      check("R1 stream_en in reset", stream_en, 0);
      check("R1 inhibit in reset", inhibit, 0);
      check("R1 log empty in reset", log_empty, 1);

      rst_n = 1'b1;
      expect_ev(4'hE, ts);                   // R1 boot record: 0xC | cause 2
      tick();
      check("R1 stream_en after boot", stream_en, 0);
      check("R1 inhibit after boot", inhibit, 0);

      sample = 1'b1; tick(3); sample = 1'b0; // R7 strobes outside Streaming are ignored

      arm = 1'b1; expect_ev(4'h1, ts); tick(); arm = 1'b0;
      check("R2 armed is not streaming", stream_en, 0);
      trig = 1'b1; expect_ev(4'h2, ts); tick(); trig = 1'b0;
      check("R2 stream_en in Streaming", stream_en, 1);
      check("R2 inhibit in Streaming", inhibit, 0);

      sample = 1'b1; tick(5); sample = 1'b0;

      // link drop while streaming: R3 then automatic Fault->Recover (R4)
      link_up = 1'b0; expect_ev(4'h3, ts); expect_ev(4'h7, ts + 1); tick();
      check("R3 inhibit on link drop", inhibit, 1);
      check("R3 stream_en off on link drop", stream_en, 0);
      check("R7 last valid count", last_valid, 5);
      tick(3);
      check("R3 inhibit held in Recover", inhibit, 1);
      check("R4 no reconnect yet", reconn_cnt, 0);
      link_up = 1'b1; expect_ev(4'h8, ts); tick();
      check("R4 reconnect counted", reconn_cnt, 1);
      check("R3 inhibit held in Resume", inhibit, 1);
      check("R5 not streaming before arm", stream_en, 0);
      arm = 1'b1; expect_ev(4'h9, ts); tick(); arm = 1'b0;
      check("R5 streaming after resume arm", stream_en, 1);
      check("R5 inhibit released", inhibit, 0);

      sample = 1'b1; tick(3); sample = 1'b0;
      dma_err = 1'b1; expect_ev(4'h4, ts); tick();
      check("R7 count preserved across fault", last_valid, 8);
      tick(3);
      check("R4 Fault held while error high", inhibit, 1);

      // release error; Resume then times out without arm (R6)
      dma_err = 1'b0; t0 = ts;
      expect_ev(4'h7, t0); expect_ev(4'h8, t0 + 1); expect_ev(4'h6, t0 + 21);
      expect_ev(4'h7, t0 + 22); expect_ev(4'h8, t0 + 23); expect_ev(4'h9, t0 + 24);
      tick(21);
      check("R6 no timeout before limit", tmo_cnt, 0);
      check("R6 still in Resume", inhibit, 1);
      tick();
      check("R6 timeout counted", tmo_cnt, 1);
      arm = 1'b1;
      tick(3);
      check("R5 restart after timeout loop", stream_en, 1);
      check("R4 reconnects after loop", reconn_cnt, 3);

      // overflow held across a Fault timeout that re-enters Fault (R6)
      buf_ovf = 1'b1; t0 = ts;
      expect_ev(4'h5, t0); expect_ev(4'h6, t0 + 20);
      tick(21);
      check("R6 Fault re-entry timeout counted", tmo_cnt, 2);
      check("R4 Fault held under overflow", inhibit, 1);
      buf_ovf = 1'b0;
      expect_ev(4'h7, ts); expect_ev(4'h8, ts + 1); expect_ev(4'h9, ts + 2);
      tick(3);
      check("R5 streaming after overflow recovery", stream_en, 1);
      check("R4 reconnect count", reconn_cnt, 4);
      tick(4);
      check("R8 all records drained", exp_q.size(), 0);
      check("R9 no overflow yet", log_ovf, 0);

      // flood the log: one timeout record per cycle, reads paused (R9)
      mon_en = 1'b0; tmo_fault = 16'd1;
      tick();
      buf_ovf = 1'b1; t0 = ts;
      tmp.push_back({4'h5, t0});
      for (int i = 1; i < 20; i++) tmp.push_back({4'h6, t0 + i});
      tick(20);
      buf_ovf = 1'b0;
      tmp.push_back({4'h7, ts}); tmp.push_back({4'h8, ts + 1}); tmp.push_back({4'h9, ts + 2});
      tick(4);
      for (int i = tmp.size() - 16; i < tmp.size(); i++) exp_q.push_back(tmp[i]);
      check("R9 overflow flag set", log_ovf, 1);
      check("R6 timeouts during flood", tmo_cnt, 21);
      mon_en = 1'b1;
      tick(20);
      check("R9 only newest 16 kept", exp_q.size(), 0);
      check("R9 log drained", log_empty, 1);
      check("R9 overflow flag sticky", log_ovf, 1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule